// File: doc/BRIEF.md
# Partitioned Packet Crossbar with Route Lookup

This block links `NPORTS` ingress ports to `NPORTS` egress ports through a fully connected crossbar. On the first beat of a packet, the ingress port uses the packet's destination identifier as an index into a route table, and the table gives the egress port. Two isolation rules are checked on that same beat. The egress port must sit in the same partition as the ingress port. The request address must fall inside the inclusive address window of the ingress port's partition. A packet that passes both checks flows beat by beat to its egress port. A packet that fails a check is consumed and discarded, and a registered violation pulse reports it. Software programs the route table, the port-to-partition map and the per-partition windows through a single-cycle write strobe.

Every egress port has its own round-robin arbiter. Pairs of ingress and egress ports that do not share an egress all move in the same cycle. Once a multi-beat packet has won an egress, it keeps that egress until its last beat is taken. Each ingress port runs a three-state machine: `ING_IDLE` (waiting for a head beat), `ING_FWD` (forwarding the body of an accepted packet) and `ING_DROP` (discarding the body of a refused packet). The transitions are: idle→fwd on an accepted legal head beat without last; idle→drop on a consumed illegal head beat without last; fwd→idle and drop→idle on an accepted last beat. Every egress arbiter runs `ARB_FREE`→`ARB_HELD` when a non-last beat is taken, and `ARB_HELD`→`ARB_FREE` when the last beat is taken.

Top module: `xs_switch`

## Requirements
- R1: After reset, all route entries are unmapped, every port is in partition 0, and every window spans the full address space. No `out_valid` and no `viol_valid` are high.
- R2: A write with `cfg_sel`=0 sets route entry `cfg_idx`. `cfg_data[PORTW-1:0]` is the egress port and `cfg_data[PORTW]` is the mapped bit. A legal head beat appears on the egress port from that entry in the same cycle, with `out_src` equal to its ingress index.
- R3: `cfg_sel`=1 sets the partition of port `cfg_idx` from `cfg_data`. A head beat whose egress port is in a different partition from its ingress port is refused with cause 1.
- R4: `cfg_sel`=2 sets the window base and `cfg_sel`=3 sets the window limit of partition `cfg_idx`. An address below the base or above the limit is refused with cause 0, and both bounds are inclusive.
- R5: When several rules fail, the cause is chosen by priority: unmapped route (cause 2) first, then partition mismatch (1), then range (0).
- R6: A refused packet is consumed in full and never reaches any egress. One cycle after its head beat is consumed, `viol_valid` pulses for exactly one cycle with the ingress index and the cause.
- R7: Ingress/egress pairs that share no egress all transfer a beat in the same cycle.
- R8: When several ingress ports target one egress, exactly one is granted, the rest see `in_ready` low, and under steady contention the winners alternate.
- R9: An egress granted to a multi-beat packet serves only that packet until its last beat is accepted.
- R10: A table write applies only to packets whose head beat arrives after the write cycle. A head beat in the same cycle as the write, and the body of a packet already in progress, use the old route.
- R11: When several ports present refused head beats in the same cycle, the lowest index is consumed and reported first. The others wait with `in_ready` low and are reported in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 route, 1 partition, 2 base, 3 limit |
| cfg_idx | input | IDW | Entry index |
| cfg_data | input | AW | Write value |
| in_valid | input | NPORTS | Ingress beat valid, one bit per port |
| in_ready | output | NPORTS | Ingress beat accepted |
| in_last | input | NPORTS | Beat ends the packet |
| in_dest | input | NPORTS*IDW | Destination identifier per port |
| in_addr | input | NPORTS*AW | Request address per port |
| in_data | input | NPORTS*DW | Payload per port |
| out_valid | output | NPORTS | Egress beat valid |
| out_ready | input | NPORTS | Egress sink ready |
| out_last | output | NPORTS | Egress beat ends the packet |
| out_data | output | NPORTS*DW | Egress payload |
| out_src | output | NPORTS*PORTW | Ingress index of each egress beat |
| viol_valid | output | 1 | Refusal pulse |
| viol_port | output | PORTW | Refused ingress port |
| viol_cause | output | 2 | 0 range, 1 partition, 2 unmapped |

## Verification
The bench builds the switch with four ports, two partitions, 3-bit destination identifiers and 8-bit addresses and payloads. With only four ports, a single cycle can load every egress at once, which exposes the non-blocking property. A two-way contention on one egress shows the arbiter alternating. Eight route entries leave unmapped identifiers to test the unmapped cause, and 8-bit windows make both inclusive bounds cheap to probe on each side.

// File: rtl/xs_pkg.sv
package xs_pkg;
    typedef enum logic [1:0] {
        CAUSE_RANGE    = 2'd0,
        CAUSE_PART     = 2'd1,
        CAUSE_UNMAPPED = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        SEL_ROUTE = 2'd0,
        SEL_PART  = 2'd1,
        SEL_BASE  = 2'd2,
        SEL_LIMIT = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ING_IDLE = 2'd0,
        ING_FWD  = 2'd1,
        ING_DROP = 2'd2
    } ing_state_e;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/xs_route_check.sv
module xs_route_check
    import xs_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int NPARTS = 4,
    parameter int IDW    = 5,
    parameter int AW     = 32,
    localparam int PORTW = $clog2(NPORTS),
    localparam int PARTW = $clog2(NPARTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [IDW-1:0]          cfg_idx,
    input  logic [AW-1:0]           cfg_data,
    input  logic [NPORTS*IDW-1:0]   in_dest,
    input  logic [NPORTS*AW-1:0]    in_addr,
    output logic [NPORTS-1:0]       hd_ok,
    output logic [NPORTS*PORTW-1:0] hd_port,
    output logic [NPORTS*2-1:0]     hd_cause
);
    localparam int NROUTES = 1 << IDW;

    logic             route_vld  [NROUTES];
    logic [PORTW-1:0] route_port [NROUTES];
    logic [PARTW-1:0] port_part  [NPORTS];
    logic [AW-1:0]    win_base   [NPARTS];
    logic [AW-1:0]    win_lim    [NPARTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NROUTES; k++) begin
                route_vld[k]  <= 1'b0;
                route_port[k] <= '0;
            end
            for (int k = 0; k < NPORTS; k++) port_part[k] <= '0;
            for (int k = 0; k < NPARTS; k++) begin
                win_base[k] <= '0;
                win_lim[k]  <= '1;
            end
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_ROUTE: begin
                    route_vld[cfg_idx]  <= cfg_data[PORTW] &&
                                           (int'(cfg_data[PORTW-1:0]) < NPORTS);
                    route_port[cfg_idx] <= cfg_data[PORTW-1:0];
                end
                SEL_PART: begin
                    if (int'(cfg_idx) < NPORTS)
                        port_part[cfg_idx[PORTW-1:0]] <= cfg_data[PARTW-1:0];
                end
                SEL_BASE: begin
                    if (int'(cfg_idx) < NPARTS)
                        win_base[cfg_idx[PARTW-1:0]] <= cfg_data;
                end
                SEL_LIMIT: begin
                    if (int'(cfg_idx) < NPARTS)
                        win_lim[cfg_idx[PARTW-1:0]] <= cfg_data;
                end
            endcase
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_look
        logic [IDW-1:0]   dest;
        logic [AW-1:0]    addr;
        logic [PORTW-1:0] rp;
        logic [PARTW-1:0] sp;
        logic [PARTW-1:0] dp;
        logic             in_win;
        logic             ok;
        cause_e           cause;

        always_comb begin
            dest   = in_dest[p*IDW +: IDW];
            addr   = in_addr[p*AW +: AW];
            rp     = route_port[dest];
            sp     = port_part[p];
            dp     = port_part[rp];
            in_win = (addr >= win_base[sp]) && (addr <= win_lim[sp]);
            ok     = 1'b0;
            if (!route_vld[dest])  cause = CAUSE_UNMAPPED;
            else if (sp != dp)     cause = CAUSE_PART;
            else if (!in_win)      cause = CAUSE_RANGE;
            else begin
                cause = CAUSE_RANGE;
                ok    = 1'b1;
            end
        end

        assign hd_ok[p]                  = ok;
        assign hd_port[p*PORTW +: PORTW] = rp;
        assign hd_cause[p*2 +: 2]        = cause;
    end
endmodule

// File: rtl/xs_ingress.sv
module xs_ingress
    import xs_pkg::*;
#(
    parameter int NPORTS = 8,
    localparam int PORTW = $clog2(NPORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             hd_ok,
    input  logic [PORTW-1:0] hd_port,
    input  logic             fwd_gnt,
    input  logic             viol_gnt,
    output logic             in_ready,
    output logic             req_valid,
    output logic [PORTW-1:0] req_port,
    output logic             viol_req
);
    ing_state_e       st, st_n;
    logic [PORTW-1:0] lat_port, lat_port_n;
    logic             take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ING_IDLE;
            lat_port <= '0;
        end else begin
            st       <= st_n;
            lat_port <= lat_port_n;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        req_port  = lat_port;
        viol_req  = 1'b0;
        in_ready  = 1'b0;
        unique case (st)
            ING_IDLE: begin
                if (in_valid && hd_ok) begin
                    req_valid = 1'b1;
                    req_port  = hd_port;
                    in_ready  = fwd_gnt;
                end else if (in_valid) begin
                    viol_req = 1'b1;
                    in_ready = viol_gnt;
                end
            end
            ING_FWD: begin
                req_valid = in_valid;
                in_ready  = fwd_gnt;
            end
            ING_DROP: in_ready = 1'b1;
            default: ;
        endcase
    end

    assign take = in_valid && in_ready;

    always_comb begin
        st_n       = st;
        lat_port_n = lat_port;
        unique case (st)
            ING_IDLE: begin
                if (take && !in_last) begin
                    st_n       = hd_ok ? ING_FWD : ING_DROP;
                    lat_port_n = hd_port;
                end
            end
            ING_FWD:  if (take && in_last) st_n = ING_IDLE;
            ING_DROP: if (take && in_last) st_n = ING_IDLE;
            default:  st_n = ING_IDLE;
        endcase
    end

    // R6
    drop_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ING_DROP && in_valid) |-> (in_ready && !req_valid));

    // R10
    body_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ING_FWD && in_valid && in_ready && !in_last) |=>
            (st == ING_FWD && req_port == $past(req_port)));
endmodule

// File: rtl/xs_rr_arbiter.sv
module xs_rr_arbiter
    import xs_pkg::*;
#(
    parameter int NPORTS = 8,
    localparam int PORTW = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] req,
    input  logic              out_ready,
    input  logic              xfer_last,
    output logic [NPORTS-1:0] gnt,
    output logic [PORTW-1:0]  sel_idx,
    output logic              sel_any
);
    arb_state_e       st, st_n;
    logic [PORTW-1:0] owner, owner_n;
    logic [PORTW-1:0] ptr, ptr_n;
    logic             xfer;

    function automatic logic [PORTW-1:0] wrap_inc(input logic [PORTW-1:0] v);
        return (int'(v) == NPORTS - 1) ? '0 : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ARB_FREE;
            owner <= '0;
            ptr   <= '0;
        end else begin
            st    <= st_n;
            owner <= owner_n;
            ptr   <= ptr_n;
        end
    end

    always_comb begin
        int cand;
        gnt     = '0;
        sel_idx = '0;
        sel_any = 1'b0;
        unique case (st)
            ARB_HELD: begin
                if (req[owner]) begin
                    gnt[owner] = 1'b1;
                    sel_idx    = owner;
                    sel_any    = 1'b1;
                end
            end
            ARB_FREE: begin
                for (int k = 0; k < NPORTS; k++) begin
                    cand = int'(ptr) + k;
                    if (cand >= NPORTS) cand = cand - NPORTS;
                    if (!sel_any && req[cand]) begin
                        gnt[cand] = 1'b1;
                        sel_idx   = PORTW'(cand);
                        sel_any   = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    assign xfer = sel_any && out_ready;

    always_comb begin
        st_n    = st;
        owner_n = owner;
        ptr_n   = ptr;
        unique case (st)
            ARB_FREE: begin
                if (xfer && !xfer_last) begin
                    st_n    = ARB_HELD;
                    owner_n = sel_idx;
                end else if (xfer) begin
                    ptr_n = wrap_inc(sel_idx);
                end
            end
            ARB_HELD: begin
                if (xfer && xfer_last) begin
                    st_n  = ARB_FREE;
                    ptr_n = wrap_inc(owner);
                end
            end
            default: st_n = ARB_FREE;
        endcase
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9
    held_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_any && out_ready && !xfer_last) |=>
            (st == ARB_HELD && owner == $past(sel_idx)));
endmodule

// File: rtl/xs_switch.sv
module xs_switch
    import xs_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int NPARTS = 4,
    parameter int IDW    = 5,
    parameter int AW     = 32,
    parameter int DW     = 64,
    localparam int PORTW = $clog2(NPORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [IDW-1:0]          cfg_idx,
    input  logic [AW-1:0]           cfg_data,
    input  logic [NPORTS-1:0]       in_valid,
    output logic [NPORTS-1:0]       in_ready,
    input  logic [NPORTS-1:0]       in_last,
    input  logic [NPORTS*IDW-1:0]   in_dest,
    input  logic [NPORTS*AW-1:0]    in_addr,
    input  logic [NPORTS*DW-1:0]    in_data,
    output logic [NPORTS-1:0]       out_valid,
    input  logic [NPORTS-1:0]       out_ready,
    output logic [NPORTS-1:0]       out_last,
    output logic [NPORTS*DW-1:0]    out_data,
    output logic [NPORTS*PORTW-1:0] out_src,
    output logic                    viol_valid,
    output logic [PORTW-1:0]        viol_port,
    output logic [1:0]              viol_cause
);
    logic [NPORTS-1:0]       hd_ok;
    logic [NPORTS*PORTW-1:0] hd_port;
    logic [NPORTS*2-1:0]     hd_cause;
    logic [NPORTS-1:0]       ing_req;
    logic [NPORTS*PORTW-1:0] ing_port;
    logic [NPORTS-1:0]       viol_req;
    logic [NPORTS-1:0]       viol_gnt;
    logic [NPORTS-1:0]       fwd_gnt;
    logic [NPORTS-1:0]       gnt_m [NPORTS];
    logic [PORTW-1:0]        viol_pick;

    xs_route_check #(
        .NPORTS (NPORTS), .NPARTS (NPARTS), .IDW (IDW), .AW (AW)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .in_dest  (in_dest),
        .in_addr  (in_addr),
        .hd_ok    (hd_ok),
        .hd_port  (hd_port),
        .hd_cause (hd_cause)
    );

    for (genvar i = 0; i < NPORTS; i++) begin : g_ing
        xs_ingress #(.NPORTS (NPORTS)) u_ing (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[i]),
            .in_last   (in_last[i]),
            .hd_ok     (hd_ok[i]),
            .hd_port   (hd_port[i*PORTW +: PORTW]),
            .fwd_gnt   (fwd_gnt[i]),
            .viol_gnt  (viol_gnt[i]),
            .in_ready  (in_ready[i]),
            .req_valid (ing_req[i]),
            .req_port  (ing_port[i*PORTW +: PORTW]),
            .viol_req  (viol_req[i])
        );
    end

    for (genvar o = 0; o < NPORTS; o++) begin : g_out
        logic [NPORTS-1:0] req_o;
        logic [PORTW-1:0]  sel_o;
        logic              any_o;

        always_comb begin
            for (int i = 0; i < NPORTS; i++)
                req_o[i] = ing_req[i] && (ing_port[i*PORTW +: PORTW] == PORTW'(o));
        end

        xs_rr_arbiter #(.NPORTS (NPORTS)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_o),
            .out_ready (out_ready[o]),
            .xfer_last (in_last[sel_o]),
            .gnt       (gnt_m[o]),
            .sel_idx   (sel_o),
            .sel_any   (any_o)
        );

        assign out_valid[o]                = any_o;
        assign out_last[o]                 = any_o && in_last[sel_o];
        assign out_data[o*DW +: DW]        = in_data[sel_o*DW +: DW];
        assign out_src[o*PORTW +: PORTW]   = sel_o;
    end

    always_comb begin
        fwd_gnt = '0;
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                if (gnt_m[o][i] && out_ready[o]) fwd_gnt[i] = 1'b1;
    end

    always_comb begin
        viol_gnt  = '0;
        viol_pick = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (viol_req[i]) begin
                viol_gnt  = '0;
                viol_gnt[i] = 1'b1;
                viol_pick = PORTW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_port  <= '0;
            viol_cause <= '0;
        end else begin
            viol_valid <= |viol_req;
            if (|viol_req) begin
                viol_port  <= viol_pick;
                viol_cause <= hd_cause[viol_pick*2 +: 2];
            end
        end
    end

    // R6
    viol_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_cause != 2'd3 && int'(viol_port) < NPORTS));

    // R11
    viol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(viol_req & in_ready));
endmodule

// File: tb/test_xs_switch.sv
module test_xs_switch;
    localparam int N     = 4;
    localparam int PARTS = 2;
    localparam int IDW   = 3;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int PW    = 2;

    // src, dest, addr(2 hex), ok, port, cause
    localparam logic [27:0] VEC [13] = '{
        28'h0110110, 28'h047F110, 28'h1020100, 28'h010F000,
        28'h1080000, 28'h0220001, 28'h2380130, 28'h32EF120,
        28'h3090001, 28'h2590002, 28'h0605002, 28'h2105001,
        28'h23F0000
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [1:0] cfg_sel;
    logic [IDW-1:0] cfg_idx;
    logic [AW-1:0] cfg_data;
    logic [N-1:0] in_valid, in_ready, in_last;
    logic [N*IDW-1:0] in_dest;
    logic [N*AW-1:0] in_addr;
    logic [N*DW-1:0] in_data;
    logic [N-1:0] out_valid, out_ready, out_last;
    logic [N*DW-1:0] out_data;
    logic [N*PW-1:0] out_src;
    logic viol_valid;
    logic [PW-1:0] viol_port;
    logic [1:0] viol_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xs_switch #(.NPORTS (N), .NPARTS (PARTS), .IDW (IDW), .AW (AW), .DW (DW)) i_xs_switch (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_idx (cfg_idx), .cfg_data (cfg_data), .in_valid (in_valid),
        .in_ready (in_ready), .in_last (in_last), .in_dest (in_dest),
        .in_addr (in_addr), .in_data (in_data), .out_valid (out_valid),
        .out_ready (out_ready), .out_last (out_last), .out_data (out_data),
        .out_src (out_src), .viol_valid (viol_valid), .viol_port (viol_port),
        .viol_cause (viol_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int s, input int d, input int a, input int dat, input bit last);
        in_valid[s] = 1'b1;
        in_last[s]  = last;
        in_dest[s*IDW +: IDW] = IDW'(d);
        in_addr[s*AW +: AW]   = AW'(a);
        in_data[s*DW +: DW]   = DW'(dat);
    endtask

    task automatic idle_all();
        in_valid = '0;
        in_last  = '0;
    endtask

    task automatic cfg_wr(input int sel, input int idx, input int dat);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = IDW'(idx); cfg_data = AW'(dat);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int prev;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_data = '0;
        in_valid = '0; in_last = '0; in_dest = '0; in_addr = '0; in_data = '0;
        out_ready = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 viol_valid", 32'(viol_valid), 0);
        @(negedge clk);
        // R1 all routes unmapped after reset
        drive(0, 0, 0, 8'h11, 1'b1);
        #1;
        chk("R1 no forward", 32'(out_valid), 0);
        @(negedge clk); idle_all();
        chk("R1 viol_valid", 32'(viol_valid), 1);
        chk("R1 cause unmapped", 32'(viol_cause), 2);

        for (int r = 0; r < 4; r++) cfg_wr(0, r, 4 | r);
        cfg_wr(0, 4, 4 | 1);
        cfg_wr(1, 2, 1);
        cfg_wr(1, 3, 1);
        cfg_wr(2, 0, 8'h10); cfg_wr(3, 0, 8'h7F);
        cfg_wr(2, 1, 8'h80); cfg_wr(3, 1, 8'hEF);

        // R2 R3 R4 R5 table walk
        for (int v = 0; v < 13; v++) begin
            int s, d, a, ok, p, c;
            string tag;
            s = int'(VEC[v][27:24]); d = int'(VEC[v][23:20]); a = int'(VEC[v][19:12]);
            ok = int'(VEC[v][11:8]); p = int'(VEC[v][7:4]); c = int'(VEC[v][3:0]);
            tag = ok != 0 ? "R2" : (c == 2 ? "R5" : (c == 1 ? "R3" : "R4"));
            drive(s, d, a, v + 8'h40, 1'b1);
            #1;
            chk(tag, 32'(in_ready[s]), 1);
            if (ok != 0) begin
                chk({tag, " out_valid"}, 32'(out_valid), 32'(1 << p));
                chk({tag, " out_src"}, 32'(out_src[p*PW +: PW]), 32'(s));
                chk({tag, " out_data"}, 32'(out_data[p*DW +: DW]), 32'(v + 8'h40));
            end else begin
                chk({tag, " no forward"}, 32'(out_valid), 0);
            end
            @(negedge clk); idle_all();
            chk({tag, " viol_valid"}, 32'(viol_valid), 32'(ok == 0));
            if (ok == 0) begin
                chk({tag, " viol_port"}, 32'(viol_port), 32'(s));
                chk({tag, " viol_cause"}, 32'(viol_cause), 32'(c));
            end
        end

        // R7 four disjoint pairs in one cycle
        drive(0, 1, 8'h20, 1, 1'b1); drive(1, 0, 8'h30, 2, 1'b1);
        drive(2, 3, 8'h90, 3, 1'b1); drive(3, 2, 8'hA0, 4, 1'b1);
        #1;
        chk("R7 out_valid", 32'(out_valid), 32'hF);
        chk("R7 in_ready", 32'(in_ready), 32'hF);
        chk("R7 src1", 32'(out_src[1*PW +: PW]), 0);
        chk("R7 src2", 32'(out_src[2*PW +: PW]), 3);
        @(negedge clk); idle_all();

        // R8 two ports contend for egress 1
        prev = -1;
        for (int k = 0; k < 4; k++) begin
            int w;
            drive(0, 1, 8'h20, 8'h50, 1'b1); drive(1, 1, 8'h21, 8'h51, 1'b1);
            #1;
            chk("R8 single grant", 32'($countones(in_ready[1:0])), 1);
            w = in_ready[0] ? 0 : 1;
            chk("R8 out_src", 32'(out_src[1*PW +: PW]), 32'(w));
            if (prev >= 0) chk("R8 alternate", 32'(w != prev), 1);
            prev = w;
            @(negedge clk);
        end
        idle_all();

        // R9 packet holds egress until last
        drive(0, 1, 8'h20, 8'hA1, 1'b0);
        #1; chk("R9 head", 32'(in_ready[0]), 1);
        @(negedge clk);
        drive(0, 1, 8'h20, 8'hA2, 1'b0); drive(1, 1, 8'h22, 8'hB1, 1'b1);
        #1;
        chk("R9 owner ready", 32'(in_ready[1:0]), 32'b01);
        chk("R9 owner src", 32'(out_src[1*PW +: PW]), 0);
        @(negedge clk);
        drive(0, 1, 8'h20, 8'hA3, 1'b1);
        #1;
        chk("R9 tail ready", 32'(in_ready[1:0]), 32'b01);
        chk("R9 tail last", 32'(out_last[1]), 1);
        @(negedge clk);
        in_valid[0] = 1'b0;
        #1;
        chk("R9 release", 32'(in_ready[1]), 1);
        chk("R9 release src", 32'(out_src[1*PW +: PW]), 1);
        @(negedge clk); idle_all();

        // R10 write during head beat keeps old route
        drive(0, 4, 8'h20, 8'hC1, 1'b0);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = 3'd4; cfg_data = 8'h04;
        #1;
        chk("R10 head old route", 32'(out_valid), 32'b0010);
        @(negedge clk);
        cfg_we = 1'b0;
        drive(0, 4, 8'h20, 8'hC2, 1'b1);
        #1;
        chk("R10 body old route", 32'(out_valid), 32'b0010);
        @(negedge clk);
        drive(0, 4, 8'h20, 8'hC3, 1'b1);
        #1;
        chk("R10 new head new route", 32'(out_valid), 32'b0001);
        @(negedge clk); idle_all();

        // R6 refused multi-beat packet is sunk with one pulse
        drive(0, 2, 8'h20, 8'hD1, 1'b0);
        #1;
        chk("R6 head sunk", 32'(in_ready[0]), 1);
        chk("R6 no forward", 32'(out_valid), 0);
        @(negedge clk);
        chk("R6 pulse", 32'(viol_valid), 1);
        chk("R6 cause", 32'(viol_cause), 1);
        drive(0, 2, 8'h20, 8'hD2, 1'b1);
        #1;
        chk("R6 body sunk", 32'(in_ready[0]), 1);
        chk("R6 body no forward", 32'(out_valid), 0);
        @(negedge clk); idle_all();
        chk("R6 single pulse", 32'(viol_valid), 0);

        // R11 simultaneous refusals, lowest first
        drive(0, 2, 8'h20, 1, 1'b1); drive(2, 5, 8'h90, 2, 1'b1);
        #1;
        chk("R11 first ready", 32'(in_ready), 32'b0001);
        @(negedge clk);
        in_valid[0] = 1'b0;
        chk("R11 first port", 32'(viol_port), 0);
        chk("R11 first cause", 32'(viol_cause), 1);
        #1;
        chk("R11 second ready", 32'(in_ready[2]), 1);
        @(negedge clk); idle_all();
        chk("R11 second valid", 32'(viol_valid), 1);
        chk("R11 second port", 32'(viol_port), 2);
        chk("R11 second cause", 32'(viol_cause), 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule